// File: doc/BRIEF.md
# Memory Boundary Scan Test Port

This block is the test access port of a synchronous memory device. It is clocked by the test clock and steered by the mode-select line. A sixteen-state controller walks the usual capture, shift, pause and update phases. The instruction register is three bits wide. Three data paths can sit between the serial input and the serial output: a one-bit bypass stage, a fixed 32-bit identification word, and an 85-bit boundary chain that loads from a parallel capture bus fed by the IO ring.

The decoded instruction drives two outputs. One forces the memory output drivers to high impedance. The other is a two-bit code that names the data path now in use. Whatever is shifted into the boundary chain is copied to a parallel update latch in the update phase; during the external-test instruction that latch drives the pad side. An optional asynchronous active-low reset returns the port to its reset state. Five clocks with the mode line high do the same.

Top module: `mem_scan_tap`

## Requirements
- R1: While trst_n is low, and after a reset by it, the active instruction is IDCODE (001). So dr_sel reads 1, force_hiz is 0, and the first data shift returns the identification word; asserting trst_n clears force_hiz at once, with no clock.
- R2: Five consecutive rising clocks with tms high reach Test-Logic-Reset from any state, which reloads IDCODE (dr_sel 1, force_hiz 0).
- R3: In Capture-IR the instruction shift stage loads 001, so an instruction shift returns 1, 0, 0, in that order, on tdo.
- R4: A new instruction takes effect only on the falling clock in Update-IR; dr_sel and force_hiz keep their old values through the whole instruction shift and Exit1-IR.
- R5: The identification word shifts out LSB first as {rev 000, depth 01011, width 100101, type 001001, vendor 00000110100, 1} from bit 31 down to bit 0.
- R6: BYPASS (111) selects the one-bit path (dr_sel 0). It captures 0, so the output is the input delayed by one shift.
- R7: The unused codes 011, 101 and 110 act as BYPASS: dr_sel 0 and force_hiz 0.
- R8: EXTEST (000) and SAMPLE Z (010) set force_hiz to 1 and dr_sel to 2. In Capture-DR the chain loads ring_capture, and that value shifts out LSB first, unaffected by later changes of ring_capture.
- R9: SAMPLE/PRELOAD (100) selects the boundary chain (dr_sel 2) and captures ring_capture, with force_hiz 0.
- R10: pad_update changes only on the falling clock in Update-DR while the boundary chain is selected; it then holds the 85 bits last shifted in, with the first bit shifted in at bit 0.
- R11: tdo and tdo_en change on the falling clock. tdo_en is 1 only for the cycles spent in Shift-IR or Shift-DR, and tdo is 0 whenever tdo_en is 0.
- R12: dr_sel encodes the active data path as 0 bypass, 1 identification, 2 boundary chain, and never shows 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising clock |
| tdi | input | 1 | Serial data in, sampled on the rising clock |
| ring_capture | input | 85 | Parallel IO-ring value loaded into the boundary chain in Capture-DR |
| tdo | output | 1 | Serial data out, changes on the falling clock |
| tdo_en | output | 1 | Serial output valid (shift states only) |
| force_hiz | output | 1 | Forces memory output drivers to high impedance |
| dr_sel | output | 2 | Active data path: 0 bypass, 1 identification, 2 boundary |
| pad_update | output | 85 | Parallel update latch for the pad side |

## Verification
Capture and shift share the boundary chain. The capture bus can change in the same cycles in which earlier captured bits are still leaving on tdo. The bench inverts ring_capture on every shift clock during boundary shifts. The scoreboard accepts only the bits captured at the Capture-DR edge. A second overlap is reset against instruction state: the five-ones path and trst_n are each applied while EXTEST is active, and the bench checks that force_hiz falls and the identification path returns.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  localparam logic [1:0] PATH_BYPASS = 2'd0;
  localparam logic [1:0] PATH_IDENT  = 2'd1;
  localparam logic [1:0] PATH_CHAIN  = 2'd2;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= state_d;
  end
endmodule

// File: rtl/tap_instr.sv
module tap_instr
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_q,
  output logic [1:0]      path,
  output logic            force_hiz
);
  logic [IR_W-1:0] ir_sh;
  logic            cap_en, sh_en, upd_en, rst_en;

  assign cap_en = (state == ST_CAP_IR);
  assign sh_en  = (state == ST_SH_IR);
  assign upd_en = (state == ST_UPD_IR);
  assign rst_en = (state == ST_RESET);
  assign ir_lsb = ir_sh[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sh <= IR_CAPTURE;
    else if (cap_en) ir_sh <= IR_CAPTURE;
    else if (sh_en)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     ir_q <= OP_IDCODE;
    else if (rst_en) ir_q <= OP_IDCODE;
    else if (upd_en) ir_q <= ir_sh;
  end

  always_comb begin
    force_hiz = 1'b0;
    unique case (ir_q)
      OP_EXTEST, OP_SAMPLEZ: begin path = PATH_CHAIN; force_hiz = 1'b1; end
      OP_SAMPLE:             path = PATH_CHAIN;
      OP_IDCODE:             path = PATH_IDENT;
      default:               path = PATH_BYPASS;
    endcase
  end
endmodule

// File: rtl/tap_data.sv
module tap_data
  import tap_pkg::*;
#(
  parameter int          CHAIN_W  = 85,
  parameter logic [31:0] IDENT    = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  input  tap_state_t         state,
  input  logic [1:0]         path,
  input  logic [CHAIN_W-1:0] ring_capture,
  output logic [CHAIN_W-1:0] pad_update,
  output logic               dr_lsb
);
  logic               byp_q;
  logic [31:0]        id_sh;
  logic [CHAIN_W-1:0] chain_sh;
  logic               cap_en, sh_en, upd_en;

  assign cap_en = (state == ST_CAP_DR);
  assign sh_en  = (state == ST_SH_DR);
  assign upd_en = (state == ST_UPD_DR) && (path == PATH_CHAIN);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q    <= 1'b0;
      id_sh    <= '0;
      chain_sh <= '0;
    end else begin
      unique case (path)
        PATH_CHAIN: begin
          if (cap_en)     chain_sh <= ring_capture;
          else if (sh_en) chain_sh <= {tdi, chain_sh[CHAIN_W-1:1]};
        end
        PATH_IDENT: begin
          if (cap_en)     id_sh <= IDENT;
          else if (sh_en) id_sh <= {tdi, id_sh[31:1]};
        end
        default: begin
          if (cap_en)     byp_q <= 1'b0;
          else if (sh_en) byp_q <= tdi;
        end
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     pad_update <= '0;
    else if (upd_en) pad_update <= chain_sh;
  end

  always_comb begin
    unique case (path)
      PATH_CHAIN: dr_lsb = chain_sh[0];
      PATH_IDENT: dr_lsb = id_sh[0];
      default:    dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/mem_scan_tap.sv
module mem_scan_tap
  import tap_pkg::*;
#(
  parameter int         CHAIN_W   = 85,
  parameter logic [2:0] ID_REV    = 3'b000,
  parameter logic [4:0] ID_DEPTH  = 5'b01011,
  parameter logic [5:0] ID_WIDTH  = 6'b100101,
  parameter logic [5:0] ID_TYPE   = 6'b001001,
  parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] ring_capture,
  output logic               tdo,
  output logic               tdo_en,
  output logic               force_hiz,
  output logic [1:0]         dr_sel,
  output logic [CHAIN_W-1:0] pad_update
);
  localparam logic [31:0] IDENT = {ID_REV, ID_DEPTH, ID_WIDTH, ID_TYPE, ID_VENDOR, 1'b1};

  tap_state_t      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  logic            out_bit, out_en;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state));

  tap_instr u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
    .ir_lsb(ir_lsb), .ir_q(ir_q), .path(dr_sel), .force_hiz(force_hiz)
  );

  tap_data #(.CHAIN_W(CHAIN_W), .IDENT(IDENT)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state), .path(dr_sel),
    .ring_capture(ring_capture), .pad_update(pad_update), .dr_lsb(dr_lsb)
  );

  always_comb begin
    out_en  = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
    out_bit = 1'b0;
    if (tap_state == ST_SH_IR)      out_bit = ir_lsb;
    else if (tap_state == ST_SH_DR) out_bit = dr_lsb;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= out_bit;
      tdo_en <= out_en;
    end
  end
endmodule

// File: rtl/mem_scan_tap_chk.sv
module mem_scan_tap_chk
  import tap_pkg::*;
#(
  parameter int CHAIN_W = 85
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdo,
  input  logic               tdo_en,
  input  logic               force_hiz,
  input  logic [1:0]         dr_sel,
  input  logic [CHAIN_W-1:0] pad_update,
  input  tap_state_t         tap_state,
  input  logic [IR_W-1:0]    ir_q
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones <= 3'd0;
    else if (!tms)        ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (tap_state == ST_RESET));

  assert_ir_update_only_R4: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_q) |-> (tap_state == ST_UPD_IR || tap_state == ST_RESET));

  assert_hiz_on_chain_R8: assert property (@(posedge tck) disable iff (!trst_n)
    force_hiz |-> (dr_sel == PATH_CHAIN));

  assert_pad_in_update_R10: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(pad_update) |-> (tap_state == ST_UPD_DR));

  assert_quiet_tdo_R11: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

  assert_sel_code_R12: assert property (@(posedge tck) disable iff (!trst_n)
    dr_sel != 2'd3);
endmodule

bind mem_scan_tap mem_scan_tap_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo), .tdo_en(tdo_en),
  .force_hiz(force_hiz), .dr_sel(dr_sel), .pad_update(pad_update),
  .tap_state(tap_state), .ir_q(ir_q)
);

// File: tb/mem_scan_tap_test.sv
`timescale 1ns/1ps
module mem_scan_tap_test;
  localparam int W = 85;
  localparam logic [31:0] ID_EXP = {3'b000, 5'b01011, 6'b100101, 6'b001001, 11'b00000110100, 1'b1};

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tms = 1'b1;
  logic         tdi = 1'b0;
  logic [W-1:0] ring_capture = '0;
  logic         tdo, tdo_en, force_hiz;
  logic [1:0]   dr_sel;
  logic [W-1:0] pad_update;

  int tests = 0;
  int fails = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2.5 tck = ~tck;

  mem_scan_tap uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ring_capture(ring_capture),
    .tdo(tdo), .tdo_en(tdo_en), .force_hiz(force_hiz), .dr_sel(dr_sel),
    .pad_update(pad_update)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit per valid serial output cycle
  always @(negedge tck) begin
    #1;
    if (tdo_en) begin
      if (exp_q.size() == 0) chk("R11 unexpected shift", {127'd0, tdo_en}, 128'd0);
      else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {127'd0, tdo}, {127'd0, e});
      end
    end
  end

  task automatic push(input logic b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic shift_ir(input logic [2:0] code);
    logic [1:0] sel0;
    logic       hiz0;
    sel0 = dr_sel;
    hiz0 = force_hiz;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    push(1'b1, "R3"); push(1'b0, "R3"); push(1'b0, "R3");
    for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
    chk("R4 sel held", {126'd0, dr_sel}, {126'd0, sel0});
    chk("R4 hiz held", {127'd0, force_hiz}, {127'd0, hiz0});
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din, input logic [127:0] dexp,
                          input string t, input logic scramble);
    logic [W-1:0] pad0;
    pad0 = pad_update;
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R11 en low on entry", {127'd0, tdo_en}, 128'd0);
    for (int i = 0; i < n; i++) begin
      push(dexp[i], t);
      if (scramble) ring_capture = ~ring_capture;
      tick(i == n - 1, din[i]);
    end
    chk("R11 en held to fall", {127'd0, tdo_en}, 128'd1);
    chk("R10 pad held", {43'd0, pad_update}, {43'd0, pad0});
    tick(1, 0); tick(0, 0);
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] v;
    v = '0;
    for (int i = 0; i < W; i++) v[i] = ((i * seed + 3) % 7) < 3;
    return v;
  endfunction

  task automatic bypass_check(input string t);
    // input 1,1,0,1 -> output 0 then input delayed
    shift_dr(4, 128'b1011, 128'b0110, t, 1'b0);
  endtask

  initial begin
    #999000;
    chk("watchdog", 128'd1, 128'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge tck);
    #1;
    chk("R1 sel in reset", {126'd0, dr_sel}, 128'd1);
    chk("R1 hiz in reset", {127'd0, force_hiz}, 128'd0);
    chk("R11 idle tdo", {126'd0, tdo_en, tdo}, 128'd0);
    trst_n = 1'b1;
    tick(0, 0);
    shift_dr(32, 128'd0, {96'd0, ID_EXP}, "R5", 1'b0);

    shift_ir(3'b111);
    chk("R6 bypass sel", {126'd0, dr_sel}, 128'd0);
    bypass_check("R6");

    shift_ir(3'b000);
    chk("R8 extest hiz", {127'd0, force_hiz}, 128'd1);
    chk("R12 chain sel", {126'd0, dr_sel}, 128'd2);
    ring_capture = pat(5);
    shift_dr(W, pat(11), pat(5), "R8 extest", 1'b1);
    chk("R10 pad latch", {43'd0, pad_update}, pat(11));

    shift_ir(3'b010);
    chk("R8 samplez hiz", {127'd0, force_hiz}, 128'd1);
    ring_capture = pat(9);
    shift_dr(W, pat(3), pat(9), "R8 samplez", 1'b1);
    chk("R10 pad latch 2", {43'd0, pad_update}, pat(3));

    shift_ir(3'b100);
    chk("R9 sample hiz", {127'd0, force_hiz}, 128'd0);
    chk("R9 sample sel", {126'd0, dr_sel}, 128'd2);
    ring_capture = pat(13);
    shift_dr(W, pat(2), pat(13), "R9", 1'b0);

    for (int c = 0; c < 3; c++) begin
      logic [2:0] code;
      code = (c == 0) ? 3'b011 : (c == 1) ? 3'b101 : 3'b110;
      shift_ir(code);
      chk("R7 sel", {126'd0, dr_sel}, 128'd0);
      chk("R7 hiz", {127'd0, force_hiz}, 128'd0);
      bypass_check("R7");
    end

    shift_ir(3'b000);
    repeat (5) tick(1, 0);
    chk("R2 sel after ones", {126'd0, dr_sel}, 128'd1);
    chk("R2 hiz after ones", {127'd0, force_hiz}, 128'd0);
    tick(0, 0);

    shift_ir(3'b010);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    chk("R2 from pause", {127'd0, dr_sel, force_hiz}, 128'b10);
    tick(0, 0);

    shift_ir(3'b000);
    trst_n = 1'b0;
    #0.5;
    chk("R1 async hiz", {127'd0, force_hiz}, 128'd0);
    @(posedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    shift_dr(32, 128'd0, {96'd0, ID_EXP}, "R1 id after trst", 1'b0);

    chk("R11 queue drained", exp_q.size(), 128'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule